// File: doc/BRIEF.md
# Page Protection and Fault Encoder

This block decides which rights a single memory access may use and reports the fault that follows when a needed right is missing. It takes the access kind, the current privilege state, the segment's two key bits and no-execute bit, a "translation found" flag and the two-bit protection field of the matching page entry. From these it produces the granted read, write and execute rights without a clock edge. From the same inputs it also selects a fault cause and its 32-bit status code.

Faults are registered. When a qualified access violates its rights, or when no translation exists for it, the block sets a sticky fault flag, the fault class (instruction or data) and the status code. It also gives a one-cycle strobe. For data faults it captures the effective address as well. The fault stays held until the surrounding logic pulses a clear input. The block does not look up translations and does not deliver exceptions. It only supplies these signals to whatever does.

Top module: `pg_prot_fault`

## Requirements
- R1: The access key is `seg_key_user_i` when `user_mode_i` is 1, and `seg_key_sup_i` otherwise.
- R2: With key 0, protection values 0, 1 and 2 grant read and write, and value 3 grants read only. `rights_o` bit 0 is read, bit 1 is write and bit 2 is execute.
- R3: With key 1, protection value 0 grants no read or write, values 1 and 3 grant read only, and value 2 grants read and write.
- R4: `rights_o` bit 2 (execute) is 1 exactly when `seg_noexec_i` is 0, whatever the key and protection value.
- R5: A qualified fetch (`acc_kind_i`=2'b10) from a no-execute segment raises an instruction fault with code 0x10000000. This cause takes priority over a missing translation.
- R6: A qualified access with a translation present whose needed right is absent raises a denial fault. A store (2'b01) needs write and gives data code 0x0A000000. A load (2'b00, and the reserved kind 2'b11) needs read and gives data code 0x08000000.
- R7: A qualified access with `xlat_hit_i`=0 (and not covered by R5) raises a not-found fault. A fetch gives instruction code 0x40000000, a store gives data code 0x42000000 and a load gives data code 0x40000000.
- R8: A captured data fault loads `eff_addr_i` into `fault_addr_o`. A captured instruction fault leaves `fault_addr_o` unchanged, and so does a clear.
- R9: A fault appears on `fault_valid_o`, `fault_fetch_o` (1 = instruction) and `fault_code_o` on the clock after the access, with `fault_pulse_o` high for that one cycle. These outputs then hold, and later faults are ignored until a clear.
- R10: `fault_clr_i` zeroes `fault_valid_o`, `fault_fetch_o` and `fault_code_o` on the next clock. A fault presented in the same cycle as the clear is captured instead.
- R11: When `acc_valid_i` is 0, no fault is captured, whatever the other inputs are.
- R12: After reset, all fault outputs and `fault_addr_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Qualifies all access inputs this cycle |
| acc_kind_i | input | 2 | 00 load, 01 store, 10 fetch, 11 treated as load |
| user_mode_i | input | 1 | 1 when the processor is in user state |
| seg_key_user_i | input | 1 | Segment key bit used in user state |
| seg_key_sup_i | input | 1 | Segment key bit used in supervisor state |
| seg_noexec_i | input | 1 | Segment forbids instruction fetch |
| xlat_hit_i | input | 1 | A translation was found for the access |
| page_prot_i | input | 2 | Page protection field |
| eff_addr_i | input | AW | Effective address of the access |
| fault_clr_i | input | 1 | Pulse that releases a held fault |
| rights_o | output | 3 | Granted rights {exec, write, read} |
| fault_valid_o | output | 1 | A fault is held |
| fault_pulse_o | output | 1 | One-cycle strobe when a fault is captured |
| fault_fetch_o | output | 1 | Held fault is an instruction fault |
| fault_code_o | output | 32 | Held fault status code |
| fault_addr_o | output | AW | Effective address of the last data fault |

## Verification
A clear of a held fault and the capture of a new fault can fall in the same cycle. The intended result is that the new fault replaces the old one, not that the clear wins. The bench provokes this by holding a data fault and then pulsing the clear together with a fetch from a no-execute segment. It then expects the instruction code, a fresh strobe and an unchanged address register, all predicted by its own model. The same model runs an exhaustive sweep in which every access carries a clear. Each sweep step therefore exercises the clear and the capture together.

// File: rtl/pg_prot_pkg.sv
package pg_prot_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE,
    CAUSE_NOEXEC,
    CAUSE_MISS,
    CAUSE_DENY
  } cause_e;

  localparam int RIGHTS_W = 3;
  localparam int RT_RD    = 0;
  localparam int RT_WR    = 1;
  localparam int RT_EX    = 2;
  localparam int CODE_W   = 32;

  localparam logic [CODE_W-1:0] CODE_NOEXEC     = 32'h1000_0000;
  localparam logic [CODE_W-1:0] CODE_DENY_LOAD  = 32'h0800_0000;
  localparam logic [CODE_W-1:0] CODE_DENY_STORE = 32'h0A00_0000;
  localparam logic [CODE_W-1:0] CODE_DENY_FETCH = 32'h0800_0000;
  localparam logic [CODE_W-1:0] CODE_MISS_LOAD  = 32'h4000_0000;
  localparam logic [CODE_W-1:0] CODE_MISS_STORE = 32'h4200_0000;
  localparam logic [CODE_W-1:0] CODE_MISS_FETCH = 32'h4000_0000;
endpackage

// File: rtl/pg_prot_rights.sv
module pg_prot_rights
  import pg_prot_pkg::*;
(
  input  logic                user_mode_i,
  input  logic                key_user_i,
  input  logic                key_sup_i,
  input  logic                noexec_i,
  input  logic [1:0]          prot_i,
  output logic [RIGHTS_W-1:0] rights_o
);
  logic key;

  always_comb begin
    key = user_mode_i ? key_user_i : key_sup_i;
    rights_o = '0;
    if (!key) begin
      rights_o[RT_RD] = 1'b1;
      rights_o[RT_WR] = (prot_i != 2'b11);
    end else begin
      rights_o[RT_RD] = (prot_i != 2'b00);
      rights_o[RT_WR] = (prot_i == 2'b10);
    end
    rights_o[RT_EX] = !noexec_i;
  end
endmodule

// File: rtl/pg_fault_classify.sv
module pg_fault_classify
  import pg_prot_pkg::*;
(
  input  logic [1:0]          kind_i,
  input  logic                hit_i,
  input  logic                noexec_i,
  input  logic [RIGHTS_W-1:0] rights_i,
  output logic                viol_o,
  output logic                fetch_o,
  output logic [CODE_W-1:0]   code_o
);
  acc_kind_e kind;
  cause_e    cause;
  logic      need_ok;

  always_comb begin
    kind = acc_kind_e'(kind_i);
    unique case (kind)
      ACC_FETCH: need_ok = rights_i[RT_EX];
      ACC_STORE: need_ok = rights_i[RT_WR];
      default:   need_ok = rights_i[RT_RD];
    endcase

    // priority: segment no-exec, then missing translation, then denial
    if (kind == ACC_FETCH && noexec_i) cause = CAUSE_NOEXEC;
    else if (!hit_i)                    cause = CAUSE_MISS;
    else if (!need_ok)                  cause = CAUSE_DENY;
    else                                cause = CAUSE_NONE;

    unique case (cause)
      CAUSE_NOEXEC: code_o = CODE_NOEXEC;
      CAUSE_MISS:   code_o = (kind == ACC_FETCH) ? CODE_MISS_FETCH :
                             (kind == ACC_STORE) ? CODE_MISS_STORE : CODE_MISS_LOAD;
      CAUSE_DENY:   code_o = (kind == ACC_FETCH) ? CODE_DENY_FETCH :
                             (kind == ACC_STORE) ? CODE_DENY_STORE : CODE_DENY_LOAD;
      default:      code_o = '0;
    endcase

    viol_o  = (cause != CAUSE_NONE);
    fetch_o = viol_o && (kind == ACC_FETCH);
  end
endmodule

// File: rtl/pg_fault_capture.sv
module pg_fault_capture
  import pg_prot_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              viol_i,
  input  logic              fetch_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              clr_i,
  output logic              valid_o,
  output logic              pulse_o,
  output logic              fetch_o,
  output logic [CODE_W-1:0] code_o,
  output logic [AW-1:0]     addr_o
);
  logic load;

  // a new fault wins over a simultaneous clear
  assign load = acc_valid_i && viol_i && (!valid_o || clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pulse_o <= 1'b0;
      fetch_o <= 1'b0;
      code_o  <= '0;
      addr_o  <= '0;
    end else begin
      pulse_o <= load;
      if (load) begin
        valid_o <= 1'b1;
        fetch_o <= fetch_i;
        code_o  <= code_i;
        if (!fetch_i) addr_o <= addr_i;
      end else if (clr_i) begin
        valid_o <= 1'b0;
        fetch_o <= 1'b0;
        code_o  <= '0;
      end
    end
  end

  a_r9_pulse_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> valid_o);

  a_r9_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !clr_i |=> valid_o && $stable(code_o) && $stable(fetch_o) && !pulse_o);

  a_r10_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !(acc_valid_i && viol_i) |=> !valid_o && code_o == '0);

  a_r8_addr_unchanged_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && fetch_i |=> $stable(addr_o));
endmodule

// File: rtl/pg_prot_fault.sv
module pg_prot_fault
  import pg_prot_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                acc_valid_i,
  input  logic [1:0]          acc_kind_i,
  input  logic                user_mode_i,
  input  logic                seg_key_user_i,
  input  logic                seg_key_sup_i,
  input  logic                seg_noexec_i,
  input  logic                xlat_hit_i,
  input  logic [1:0]          page_prot_i,
  input  logic [AW-1:0]       eff_addr_i,
  input  logic                fault_clr_i,
  output logic [RIGHTS_W-1:0] rights_o,
  output logic                fault_valid_o,
  output logic                fault_pulse_o,
  output logic                fault_fetch_o,
  output logic [CODE_W-1:0]   fault_code_o,
  output logic [AW-1:0]       fault_addr_o
);
  logic              viol;
  logic              viol_fetch;
  logic [CODE_W-1:0] viol_code;

  pg_prot_rights u_rights (
    .user_mode_i (user_mode_i),
    .key_user_i  (seg_key_user_i),
    .key_sup_i   (seg_key_sup_i),
    .noexec_i    (seg_noexec_i),
    .prot_i      (page_prot_i),
    .rights_o    (rights_o)
  );

  pg_fault_classify u_classify (
    .kind_i   (acc_kind_i),
    .hit_i    (xlat_hit_i),
    .noexec_i (seg_noexec_i),
    .rights_i (rights_o),
    .viol_o   (viol),
    .fetch_o  (viol_fetch),
    .code_o   (viol_code)
  );

  pg_fault_capture #(.AW(AW)) u_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_valid_i (acc_valid_i),
    .viol_i      (viol),
    .fetch_i     (viol_fetch),
    .code_i      (viol_code),
    .addr_i      (eff_addr_i),
    .clr_i       (fault_clr_i),
    .valid_o     (fault_valid_o),
    .pulse_o     (fault_pulse_o),
    .fetch_o     (fault_fetch_o),
    .code_o      (fault_code_o),
    .addr_o      (fault_addr_o)
  );

  a_r4_noexec_no_exec_right: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_noexec_i |-> !rights_o[RT_EX]);

  a_r5_noexec_fetch_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_kind_i == ACC_FETCH && seg_noexec_i && (!fault_valid_o || fault_clr_i)
    |=> fault_pulse_o && fault_fetch_o && fault_code_o == CODE_NOEXEC);

  a_r11_idle_no_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !fault_pulse_o);

  a_r8_data_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_pulse_o && !fault_fetch_o |-> fault_addr_o == $past(eff_addr_i));
endmodule

// File: tb/tb_pg_prot_fault.sv
module tb_pg_prot_fault;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          acc_valid_i = 1'b0;
  logic [1:0]    acc_kind_i = '0;
  logic          user_mode_i = 1'b0;
  logic          seg_key_user_i = 1'b0;
  logic          seg_key_sup_i = 1'b0;
  logic          seg_noexec_i = 1'b0;
  logic          xlat_hit_i = 1'b0;
  logic [1:0]    page_prot_i = '0;
  logic [AW-1:0] eff_addr_i = '0;
  logic          fault_clr_i = 1'b0;
  logic [2:0]    rights_o;
  logic          fault_valid_o, fault_pulse_o, fault_fetch_o;
  logic [31:0]   fault_code_o;
  logic [AW-1:0] fault_addr_o;

  pg_prot_fault #(.AW(AW)) dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // reference state
  logic          m_valid = 1'b0, m_pulse = 1'b0, m_fetch = 1'b0;
  logic [31:0]   m_code = '0;
  logic [AW-1:0] m_addr = '0;
  string         prev_tag = "R12";

  function automatic logic [2:0] exp_rights(logic user, logic ku, logic ks, logic nx, logic [1:0] p);
    logic k;
    k = user ? ku : ks;
    return {!nx, (k ? (p == 2) : (p != 3)), !(k && p == 0)};
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_regs();
    check("R9", "fault_valid", fault_valid_o, m_valid);
    check("R9", "fault_pulse", fault_pulse_o, m_pulse);
    check(prev_tag, "fault_fetch", fault_fetch_o, m_fetch);
    check(prev_tag, "fault_code", fault_code_o, m_code);
    check("R8", "fault_addr", fault_addr_o, m_addr);
  endtask

  task automatic apply(logic v, logic [1:0] k, logic user, logic ku, logic ks, logic nx,
                       logic hit, logic [1:0] p, logic [AW-1:0] a, logic clr, string tag);
    logic [2:0]  r;
    logic        need, viol, fcls, ld;
    logic [31:0] code;
    @(negedge clk_i);
    cmp_regs();
    acc_valid_i = v; acc_kind_i = k; user_mode_i = user; seg_key_user_i = ku;
    seg_key_sup_i = ks; seg_noexec_i = nx; xlat_hit_i = hit; page_prot_i = p;
    eff_addr_i = a; fault_clr_i = clr;
    #1;
    r = exp_rights(user, ku, ks, nx, p);
    check("R1/R2/R3/R4", "rights", rights_o, r);
    need = (k == 2) ? r[2] : (k == 1) ? r[1] : r[0];
    viol = 1'b1; fcls = (k == 2); code = 0;
    if (k == 2 && nx)  code = 32'h1000_0000;
    else if (!hit)     code = (k == 1) ? 32'h4200_0000 : 32'h4000_0000;
    else if (!need)    code = (k == 1) ? 32'h0A00_0000 : 32'h0800_0000;
    else               viol = 1'b0;
    ld = v && viol && (!m_valid || clr);
    if (ld) begin
      m_valid = 1'b1; m_fetch = fcls; m_code = code;
      if (!fcls) m_addr = a;
    end else if (clr) begin
      m_valid = 1'b0; m_fetch = 1'b0; m_code = 0;
    end
    m_pulse = ld;
    prev_tag = tag;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int idx = 0;
    #(CLK_PERIOD * 2 + 1);
    // R12: reset state
    check("R12", "fault_valid", fault_valid_o, 0);
    check("R12", "fault_code", fault_code_o, 0);
    check("R12", "fault_addr", fault_addr_o, 0);
    rst_ni = 1'b1;

    // exhaustive sweep, every access with a clear so each fault is captured
    for (int k = 0; k < 4; k++)
      for (int u = 0; u < 2; u++)
        for (int ku = 0; ku < 2; ku++)
          for (int ks = 0; ks < 2; ks++)
            for (int nx = 0; nx < 2; nx++)
              for (int h = 0; h < 2; h++)
                for (int p = 0; p < 4; p++) begin
                  string t;
                  t = (k == 2 && nx == 1) ? "R5" : (h == 0) ? "R7" : "R6";
                  idx++;
                  apply(1'b1, k[1:0], u[0], ku[0], ks[0], nx[0], h[0], p[1:0],
                        32'hA000_0000 + idx * 32'h1004, 1'b1, t);
                end

    // R9: hold and ignore later faults
    apply(1, 2'b00, 0, 0, 0, 0, 0, 2'b00, 32'h1111_0000, 1, "R7");
    apply(1, 2'b01, 1, 1, 0, 0, 1, 2'b11, 32'h2222_0000, 0, "R9");
    apply(0, 2'b00, 0, 0, 0, 0, 1, 2'b00, 32'h0, 0, "R9");
    // R10: clear with simultaneous fetch fault, new fault captured, address kept (R8)
    apply(1, 2'b10, 0, 0, 0, 1, 1, 2'b10, 32'h3333_0000, 1, "R10");
    apply(0, 2'b00, 0, 0, 0, 0, 1, 2'b00, 32'h0, 0, "R10");
    // R10: plain clear
    apply(0, 2'b00, 0, 0, 0, 0, 1, 2'b00, 32'h0, 1, "R10");
    // R11: invalid access with faulting inputs
    apply(0, 2'b01, 1, 1, 1, 1, 0, 2'b00, 32'h4444_0000, 0, "R11");
    apply(0, 2'b10, 1, 1, 1, 1, 0, 2'b00, 32'h5555_0000, 0, "R11");
    // R6: reserved kind behaves as load, store denied by key 1 prot 1
    apply(1, 2'b11, 1, 1, 0, 0, 1, 2'b00, 32'h6666_0000, 0, "R6");
    apply(1, 2'b01, 1, 1, 0, 0, 1, 2'b01, 32'h7777_0000, 1, "R6");
    // R8: fetch not-found leaves address
    apply(1, 2'b10, 0, 0, 0, 0, 0, 2'b00, 32'h8888_0000, 1, "R8");
    apply(0, 2'b00, 0, 0, 0, 0, 1, 2'b00, 32'h0, 0, "R8");
    @(negedge clk_i);
    cmp_regs();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule